// File: doc/BRIEF.md
# AFSK Tone Modulator with NRZI Coding

This block turns a packet held in a byte memory into a stream of 8-bit audio samples that carry the packet as audio-frequency shift keying. Its output is meant to feed a PWM or other DAC stage that sits in front of a radio transmitter. A 16-bit phase accumulator drives a computed sine wave. A bit serializer walks the packet and picks one of two phase increments for each bit. A zero bit swaps the tone and a one bit keeps it, which is NRZI coding. The phase is never reset between bits, so the waveform stays continuous across every bit edge.

Software writes the packet length in bits and pulses a start input. The block raises busy and the push-to-talk output, then waits a settle delay for the radio. After that it fetches bytes through a read port that has one cycle of latency and sends their bits LSB first. Each bit lasts a fixed number of samples. When the programmed bit count is reached, push-to-talk and busy drop together and the sample output parks at mid-scale.

Samples leave on a valid/ready interface. A new sample is produced only on a sample-rate strobe (the system clock divided by `CLK_DIV`), and only when the previous sample has been taken. While ready is low, valid and the data stay held. The generator pauses rather than dropping a sample, so the consumer can stall the stream at any point and no phase step is lost. Start, length, read port, busy and push-to-talk are plain signals.

Top module: `afsk_tone_mod`

## Requirements
- R1: After reset, busy and push-to-talk are low, sample valid is low and the sample output is 0x80.
- R2: A start pulse while idle raises busy and push-to-talk on the next clock edge. No sample is offered for at least `SETTLE_CYC` cycles after push-to-talk rises. The frame length is captured at start, so later changes to the length input do not affect the frame.
- R3: For every sample the 16-bit phase accumulator first adds the active increment, wrapping modulo 2^16. The output is the wave value at index `idx` = accumulator bits [15:7]. With h = idx[7:0] and a = (h*(256-h)*127) >> 14, the value is 127+a when idx[8] is 0 and 127-a when idx[8] is 1.
- R4: The increment is 1800 for the low tone and 3300 for the high tone, and it starts each frame at 1800 with the phase at 0. On the first sample of every bit, a 0 bit swaps the increment (XOR with 1800^3300) and a 1 bit keeps it. The phase carries on unchanged across bit edges.
- R5: Every bit lasts exactly `SAMPLES_PER_BIT` (36) samples. Bits are sent LSB first. Bit n comes from bit n%8 of the byte at read address n>>3, and the read data arrives one cycle after the address is presented.
- R6: While ready stays high, accepted samples are spaced exactly `CLK_DIV` clock cycles apart.
- R7: While valid is high and ready is low, valid stays high and the sample data stays stable. No sample is skipped: the accepted sequence is the same for any pattern of ready.
- R8: Once the bit position equals the frame length, the next strobe ends the frame. Busy and push-to-talk fall, valid is low and the output is 0x80. A length of 0 produces no samples.
- R9: A start pulse while busy is ignored, and the current frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (acted on only when idle) |
| frame_bits_i | input | LEN_W | Frame length in bits, captured at start |
| rd_addr_o | output | LEN_W-3 | Byte address into the packet memory |
| rd_data_i | input | 8 | Byte read from the memory, one cycle after the address |
| sample_data_o | output | 8 | Audio sample, 0x80 when parked |
| sample_valid_o | output | 1 | Sample offered |
| sample_ready_i | input | 1 | Consumer takes the sample on a cycle where valid is also high |
| ptt_o | output | 1 | Push-to-talk key for the transmitter |
| busy_o | output | 1 | Frame in progress (settle and sending) |

## Verification
The bench rebuilds the full accepted sample sequence for frames of all-zero, all-one, mixed and partial-byte data, and compares every sample. This catches a missing NRZI swap or a swap on a one bit, a phase reset at bit edges, MSB-first order, a wrong table slice and a wrong bit span, because each of these shifts every later sample. One frame runs under random back-pressure with a stray start pulse and a changed length input in the middle. A design that dropped or repeated samples while stalled, or that let start or the length input disturb a running frame, would show a mismatch or a wrong total. Zero-length and partial-byte frames check the end test: a design that compared too late or too early would send one bit too many or too few, or would fail to park at 0x80 with push-to-talk released.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } mod_state_e;

  // Parabolic half-wave per half cycle: 512 points, 0..254, centred on 127.
  function automatic logic [7:0] wave_sample(input logic [8:0] idx);
    logic [21:0] h;
    logic [21:0] prod;
    logic [7:0]  amp;
    h    = {14'd0, idx[7:0]};
    prod = h * (22'd256 - h) * 22'd127;
    amp  = 8'(prod >> 14);
    wave_sample = idx[8] ? (8'd127 - amp) : (8'd127 + amp);
  endfunction

endpackage

// File: rtl/afsk_pacer.sv
module afsk_pacer #(
  parameter int CLK_DIV    = 256,
  parameter int SETTLE_CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  output logic settle_done_o,
  output logic strobe_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [SW-1:0] settle_cnt;
  logic          settle_act;
  logic [DW-1:0] div_cnt;

  assign settle_done_o = settle_act && (settle_cnt == '0);
  assign strobe_o      = run_i && (div_cnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_act <= 1'b0;
      settle_cnt <= '0;
    end else if (arm_i) begin
      settle_act <= 1'b1;
      settle_cnt <= SW'(SETTLE_CYC - 1);
    end else if (settle_act) begin
      if (settle_cnt == '0) settle_act <= 1'b0;
      else                  settle_cnt <= settle_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!run_i)   div_cnt <= '0;
    else if (strobe_o) div_cnt <= '0;
    else               div_cnt <= div_cnt + 1'b1;
  end

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R6
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= DW'(CLK_DIV - 1));

endmodule

// File: rtl/afsk_bit_serializer.sv
module afsk_bit_serializer #(
  parameter int LEN_W           = 16,
  parameter int SAMPLES_PER_BIT = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] frame_bits_i,
  input  logic             adv_i,
  output logic [LEN_W-4:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             bit_o,
  output logic             first_o,
  output logic             last_o
);
  localparam int CW = $clog2(SAMPLES_PER_BIT);

  logic [LEN_W-1:0] bit_pos;
  logic [LEN_W-1:0] len_q;
  logic [CW-1:0]    sample_idx;
  logic [7:0]       held;
  logic [7:0]       byte_now;

  assign byte_now  = (bit_pos[2:0] == 3'd0) ? rd_data_i : {1'b0, held[7:1]};
  assign bit_o     = byte_now[0];
  assign first_o   = (sample_idx == '0);
  assign last_o    = (bit_pos == len_q);
  assign rd_addr_o = bit_pos[LEN_W-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos    <= '0;
      len_q      <= '0;
      sample_idx <= '0;
      held       <= '0;
    end else if (load_i) begin
      bit_pos    <= '0;
      len_q      <= frame_bits_i;
      sample_idx <= '0;
      held       <= '0;
    end else if (adv_i) begin
      if (first_o) held <= byte_now;
      if (sample_idx == CW'(SAMPLES_PER_BIT - 1)) begin
        sample_idx <= '0;
        bit_pos    <= bit_pos + 1'b1;
      end else begin
        sample_idx <= sample_idx + 1'b1;
      end
    end
  end

  // R5
  bit_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && sample_idx == CW'(SAMPLES_PER_BIT - 1))
      |=> (sample_idx == '0 && bit_pos == $past(bit_pos) + 1'b1));

  // R8
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= len_q);

  // R8
  no_adv_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> !last_o);

endmodule

// File: rtl/afsk_nco.sv
module afsk_nco #(
  parameter int         PH_W      = 16,
  parameter int         MARK_INC  = 1800,
  parameter int         SPACE_INC = 3300,
  parameter logic [7:0] PARK      = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       step_i,
  input  logic       toggle_i,
  input  logic       park_i,
  output logic [7:0] sample_o
);
  import afsk_pkg::*;

  localparam logic [PH_W-1:0] MARK_V  = PH_W'(MARK_INC);
  localparam logic [PH_W-1:0] SPACE_V = PH_W'(SPACE_INC);
  localparam logic [PH_W-1:0] FLIP    = MARK_V ^ SPACE_V;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] inc;
  logic [PH_W-1:0] inc_n;
  logic [PH_W-1:0] phase_n;

  assign inc_n   = toggle_i ? (inc ^ FLIP) : inc;
  assign phase_n = phase + inc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      inc      <= MARK_V;
      sample_o <= PARK;
    end else if (load_i) begin
      phase <= '0;
      inc   <= MARK_V;
    end else if (park_i) begin
      sample_o <= PARK;
    end else if (step_i) begin
      inc      <= inc_n;
      phase    <= phase_n;
      sample_o <= wave_sample(phase_n[PH_W-1:PH_W-9]);
    end
  end

  // R4
  inc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == MARK_V) || (inc == SPACE_V));

  // R4
  inc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !toggle_i && !load_i && !park_i) |=> inc == $past(inc));

endmodule

// File: rtl/afsk_tone_mod.sv
module afsk_tone_mod #(
  parameter int LEN_W           = 16,
  parameter int CLK_DIV         = 256,
  parameter int SETTLE_CYC      = 80000,
  parameter int SAMPLES_PER_BIT = 36,
  parameter int MARK_INC        = 1800,
  parameter int SPACE_INC       = 3300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_bits_i,
  output logic [LEN_W-4:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       sample_data_o,
  output logic             sample_valid_o,
  input  logic             sample_ready_i,
  output logic             ptt_o,
  output logic             busy_o
);
  import afsk_pkg::*;

  localparam logic [7:0] PARK = 8'h80;

  mod_state_e state_q;
  logic       accept_start;
  logic       settle_done;
  logic       strobe;
  logic       tick;
  logic       fin;
  logic       step;
  logic       cur_bit;
  logic       first_sample;
  logic       last_bit;
  logic       ptt_q;
  logic       valid_q;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign tick         = strobe && (!valid_q || sample_ready_i);
  assign fin          = tick && last_bit;
  assign step         = tick && !last_bit;

  afsk_pacer #(
    .CLK_DIV    (CLK_DIV),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_pacer (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_i         (accept_start),
    .run_i         (state_q == ST_RUN),
    .settle_done_o (settle_done),
    .strobe_o      (strobe)
  );

  afsk_bit_serializer #(
    .LEN_W           (LEN_W),
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT)
  ) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (accept_start),
    .frame_bits_i (frame_bits_i),
    .adv_i        (step),
    .rd_addr_o    (rd_addr_o),
    .rd_data_i    (rd_data_i),
    .bit_o        (cur_bit),
    .first_o      (first_sample),
    .last_o       (last_bit)
  );

  afsk_nco #(
    .PH_W      (16),
    .MARK_INC  (MARK_INC),
    .SPACE_INC (SPACE_INC),
    .PARK      (PARK)
  ) u_nco (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept_start),
    .step_i   (step),
    .toggle_i (first_sample && !cur_bit),
    .park_i   (fin),
    .sample_o (sample_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptt_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETTLE;
          ptt_q   <= 1'b1;
        end
        ST_SETTLE: if (settle_done) state_q <= ST_RUN;
        ST_RUN: if (fin) begin
          state_q <= ST_IDLE;
          ptt_q   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              valid_q <= 1'b0;
    else if (fin)            valid_q <= 1'b0;
    else if (step)           valid_q <= 1'b1;
    else if (sample_ready_i) valid_q <= 1'b0;
  end

  assign sample_valid_o = valid_q;
  assign ptt_o          = ptt_q;
  assign busy_o         = (state_q != ST_IDLE);

  // R2
  ptt_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptt_o |-> busy_o);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid_o && !sample_ready_i)
      |=> (sample_valid_o && $stable(sample_data_o)));

  // R8
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (sample_data_o == PARK && !sample_valid_o && !ptt_o));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start_i && !fin) |=> state_q == ST_RUN);

  // R2
  no_sample_in_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> !sample_valid_o);

endmodule

// File: tb/afsk_tone_mod_bench.sv
module afsk_tone_mod_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int DIV        = 4;
  localparam int SETTLE     = 20;
  localparam int SPB        = 36;
  localparam logic [15:0] FLIP = 16'd1800 ^ 16'd3300;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] frame_bits = '0;
  logic [LEN_W-4:0] rd_addr;
  logic [7:0]       rd_data = 8'd0;
  logic [7:0]       sample_data;
  logic             sample_valid;
  logic             sample_ready = 1'b1;
  logic             ptt;
  logic             busy;

  logic [7:0] mem [0:7];
  logic [15:0] lfsr = 16'hACE1;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr[2:0]];

  afsk_tone_mod #(
    .LEN_W           (LEN_W),
    .CLK_DIV         (DIV),
    .SETTLE_CYC      (SETTLE),
    .SAMPLES_PER_BIT (SPB)
  ) u_afsk_tone_mod (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .frame_bits_i   (frame_bits),
    .rd_addr_o      (rd_addr),
    .rd_data_i      (rd_data),
    .sample_data_o  (sample_data),
    .sample_valid_o (sample_valid),
    .sample_ready_i (sample_ready),
    .ptt_o          (ptt),
    .busy_o         (busy)
  );

  function automatic logic [7:0] ref_wave(input logic [8:0] idx);
    int h;
    int a;
    h = int'(idx[7:0]);
    a = (h * (256 - h) * 127) / 16384;
    return idx[8] ? 8'(127 - a) : 8'(127 + a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_frame(input int nbits, input bit bp, input bit poke);
    int n = 0;
    int cyc = 0;
    int last_cyc = 0;
    int guard = 0;
    bit seen = 0;
    bit stalled = 0;
    bit poked = 0;
    bit rdy;
    logic [7:0] held_d = 8'd0;
    logic [15:0] ph = 16'd0;
    logic [15:0] inc = 16'd1800;
    logic [7:0] expv;
    int bpos;
    int sidx;

    @(negedge clk);
    frame_bits = LEN_W'(nbits);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    frame_bits = 16'd5;
    chk(busy && ptt, "R2 busy/ptt after start", {busy, ptt}, 3);
    while (busy && guard < 60000) begin
      cyc++;
      start = 1'b0;
      if (poke && !poked && n == SPB * 2) begin
        start = 1'b1;
        poked = 1;
      end
      if (stalled) begin
        chk(sample_valid, "R7 valid held under stall", sample_valid, 1);
        chk(sample_data == held_d, "R7 data stable under stall", sample_data, held_d);
      end
      if (!seen && sample_valid) begin
        seen = 1;
        chk(cyc >= SETTLE, "R2 settle delay before first sample", cyc, SETTLE);
        chk(ptt, "R2 ptt during samples", ptt, 1);
      end
      rdy = bp ? (lfsr[0] | lfsr[2]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sample_ready = rdy;
      if (sample_valid && rdy) begin
        bpos = n / SPB;
        sidx = n % SPB;
        if (sidx == 0 && mem[(bpos >> 3) & 7][bpos & 7] == 1'b0) inc = inc ^ FLIP;
        ph = ph + inc;
        expv = ref_wave(ph[15:7]);
        chk(sample_data == expv, "R3 R4 R5 sample value", sample_data, expv);
        if (!bp && n > 0) chk(cyc - last_cyc == DIV, "R6 sample spacing", cyc - last_cyc, DIV);
        last_cyc = cyc;
        n++;
      end
      stalled = sample_valid && !rdy;
      held_d = sample_data;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    sample_ready = 1'b1;
    chk(n == nbits * SPB, "R5 R8 sample count", n, nbits * SPB);
    chk(sample_data == 8'h80, "R8 parked output", sample_data, 8'h80);
    chk(!ptt && !sample_valid, "R8 ptt/valid low at end", {ptt, sample_valid}, 0);
    if (poke) chk(poked, "R9 stray start issued", poked, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !ptt, "R1 busy/ptt after reset", {busy, ptt}, 0);
    chk(!sample_valid, "R1 valid after reset", sample_valid, 0);
    chk(sample_data == 8'h80, "R1 output after reset", sample_data, 8'h80);

    run_frame(0, 0, 0);

    mem[0] = 8'h00; mem[1] = 8'hFF;
    run_frame(16, 0, 0);

    mem[0] = 8'hA5; mem[1] = 8'h3C;
    run_frame(13, 0, 0);

    mem[0] = 8'h5A; mem[1] = 8'h01; mem[2] = 8'h80; mem[3] = 8'hC3; mem[4] = 8'h7E;
    run_frame(40, 1, 1);

    for (int i = 0; i < 8; i++) mem[i] = 8'(i * 37 + 11);
    run_frame(64, 0, 0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule